// File: doc/BRIEF.md
# Instruction Decode and Control Generator

This block turns the opcode and function fields of a 32-bit three-operand instruction word into the full set of steering signals for a single-cycle datapath. It covers twenty-two instructions: register-register ALU operations, ALU operations with a 16-bit immediate, word load and store, three conditional branches, two direct jumps, a register jump and a system-call trap.

Each field goes through its own full one-hot decoder. Register-format instructions are those with opcode zero, and they are told apart by the function decode. The per-instruction lines are then grouped into classes (arithmetic, logic, immediate), and every datapath control is an OR over instruction or class lines. An explicit legality guard blocks register and memory writes for any encoding outside the set.

The controls are registered once, in the two-process style, so they are valid the cycle after the fields are presented. A reset clears every output.

Top module: `insn_ctrl_decoder`

## Requirements
- R1: While `rst_n` is low every output is 0, and asserting reset clears all outputs without waiting for a clock edge.
- R2: Outputs reflect the `op_i`/`fn_i` sampled at the previous rising clock edge. `insn_id_o` is one-hot for a recognized encoding, with bit order 0 add, 1 sub, 2 slt, 3 and, 4 or, 5 xor, 6 nor, 7 jr, 8 syscall, 9 lui, 10 addi, 11 slti, 12 andi, 13 ori, 14 xori, 15 lw, 16 sw, 17 j, 18 jal, 19 bltz, 20 beq, 21 bne.
- R3: With op=0, fn codes 32 add, 34 sub, 42 slt, 36 and, 37 or, 38 xor, 39 nor, 8 jr and 12 syscall are recognized. With op≠0 the codes are 15 lui, 8 addi, 10 slti, 12 andi, 13 ori, 14 xori, 35 lw, 43 sw, 2 j, 3 jal, 1 bltz, 4 beq and 5 bne, and the fn field has no effect.
- R4: `is_arith_o` is set for add, sub, slt, addi and slti. `is_logic_o` is set for and, or, xor, nor, andi, ori and xori. `is_imm_o` is set for lui, addi, slti, andi, ori and xori.
- R5: `reg_wr_o` is set for lui, every arithmetic or logic instruction, lw and jal, and for nothing else.
- R6: `dst_sel_o` is 1 (rd) for register-format ALU instructions, 2 (register 31) for jal, and 0 (rt) otherwise.
- R7: `alu_src_o` (1 = immediate operand) is set for immediate-class instructions, lw and sw.
- R8: `add_sub_o` (1 = subtract) is set for sub, slt and slti. `alu_cls_o` is 0 for lui, 1 for slt/slti, 2 for add/sub/addi/lw/sw, 3 for logic instructions, and 0 otherwise. `logic_fn_o` is 0 and/andi, 1 or/ori, 2 xor/xori, 3 nor, and 0 otherwise.
- R9: `mem_rd_o` is set only for lw and `mem_wr_o` only for sw. The two are never set together.
- R10: `wb_sel_o` is 1 (memory data) for lw, 2 (PC+1 link) for jal, and 0 (ALU result) otherwise.
- R11: `br_type_o` is 1 for beq, 2 for bne, 3 for bltz, and 0 otherwise.
- R12: `pc_sel_o` is 1 (jump target) for j and jal, 2 (register rs) for jr, 3 (trap vector) for syscall, and 0 (incremented or branch) otherwise.
- R13: `sext_o` (1 = sign-extend the immediate) is set for addi, slti, lw, sw, bltz, beq and bne. It is 0 otherwise, so andi, ori and xori zero-extend.
- R14: An unrecognized encoding gives an all-zero `insn_id_o` and clears `reg_wr_o`, `mem_rd_o` and `mem_wr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | OP_W | Opcode field |
| fn_i | input | FN_W | Function field |
| insn_id_o | output | 22 | One-hot instruction identity |
| is_arith_o | output | 1 | Arithmetic class |
| is_logic_o | output | 1 | Logic class |
| is_imm_o | output | 1 | Immediate class |
| reg_wr_o | output | 1 | Register file write enable |
| dst_sel_o | output | 2 | Destination register select |
| alu_src_o | output | 1 | Second ALU operand is the immediate |
| add_sub_o | output | 1 | Adder subtracts |
| alu_cls_o | output | 2 | ALU function class |
| logic_fn_o | output | 2 | Logic unit function |
| mem_rd_o | output | 1 | Data memory read |
| mem_wr_o | output | 1 | Data memory write |
| wb_sel_o | output | 2 | Register write-back source |
| br_type_o | output | 2 | Conditional branch kind |
| pc_sel_o | output | 2 | Next-PC source |
| sext_o | output | 1 | Immediate sign-extension |

## Verification
The bench uses the default field widths, OP_W = FN_W = 6. At these widths both code spaces are small enough to sweep completely: all 64 opcodes with a fixed function field, and all 64 function codes under opcode zero. Every unrecognized encoding is therefore driven, not just a chosen few. Directed cases add recognized opcodes paired with function values that would match a register-format instruction, a latency probe taken on either side of the clock edge, and a reset applied in the middle of a jal.

// File: rtl/icd_pkg.sv
package icd_pkg;

    localparam int N_ID = 22;
    localparam int N_R  = 9;
    localparam int N_I  = 13;

    // fn codes of the register-format group, in identity order 0..8
    localparam int R_FN_TAB [N_R] = '{32, 34, 42, 36, 37, 38, 39, 8, 12};
    // op codes of the remaining group, in identity order 9..21
    localparam int I_OP_TAB [N_I] = '{15, 8, 10, 12, 13, 14, 35, 43, 2, 3, 1, 4, 5};

    localparam int ID_ADD  = 0;
    localparam int ID_SUB  = 1;
    localparam int ID_SLT  = 2;
    localparam int ID_AND  = 3;
    localparam int ID_OR   = 4;
    localparam int ID_XOR  = 5;
    localparam int ID_NOR  = 6;
    localparam int ID_JR   = 7;
    localparam int ID_SYS  = 8;
    localparam int ID_LUI  = 9;
    localparam int ID_ADDI = 10;
    localparam int ID_SLTI = 11;
    localparam int ID_ANDI = 12;
    localparam int ID_ORI  = 13;
    localparam int ID_XORI = 14;
    localparam int ID_LW   = 15;
    localparam int ID_SW   = 16;
    localparam int ID_J    = 17;
    localparam int ID_JAL  = 18;
    localparam int ID_BLTZ = 19;
    localparam int ID_BEQ  = 20;
    localparam int ID_BNE  = 21;

    typedef struct packed {
        logic [N_ID-1:0] id;
        logic            arith;
        logic            logi;
        logic            imm;
        logic            reg_wr;
        logic [1:0]      dst_sel;
        logic            alu_src;
        logic            add_sub;
        logic [1:0]      alu_cls;
        logic [1:0]      logic_fn;
        logic            mem_rd;
        logic            mem_wr;
        logic [1:0]      wb_sel;
        logic [1:0]      br_type;
        logic [1:0]      pc_sel;
        logic            sext;
    } ctrl_t;

endpackage

// File: rtl/icd_onehot_dec.sv
module icd_onehot_dec #(
    parameter int W = 6
) (
    input  logic [W-1:0]        code_i,
    output logic [(1<<W)-1:0]   hot_o
);
    localparam int N = 1 << W;

    generate
        for (genvar g = 0; g < N; g++) begin : g_line
            assign hot_o[g] = (code_i == W'(g));
        end
    endgenerate
endmodule

// File: rtl/icd_ident.sv
module icd_ident
    import icd_pkg::*;
#(
    parameter int OP_N = 64,
    parameter int FN_N = 64
) (
    input  logic [OP_N-1:0] op_hot_i,
    input  logic [FN_N-1:0] fn_hot_i,
    output logic [N_ID-1:0] id_o,
    output logic            legal_o
);
    function automatic logic [OP_N-1:0] mk_op_mask();
        logic [OP_N-1:0] m;
        m    = '0;
        m[0] = 1'b1;
        for (int i = 0; i < N_I; i++) m[I_OP_TAB[i]] = 1'b1;
        return m;
    endfunction

    function automatic logic [FN_N-1:0] mk_fn_mask();
        logic [FN_N-1:0] m;
        m = '0;
        for (int i = 0; i < N_R; i++) m[R_FN_TAB[i]] = 1'b1;
        return m;
    endfunction

    localparam logic [OP_N-1:0] OP_USED = mk_op_mask();
    localparam logic [FN_N-1:0] FN_USED = mk_fn_mask();

    logic rtype;
    assign rtype = op_hot_i[0];

    generate
        for (genvar g = 0; g < N_R; g++) begin : g_rfmt
            assign id_o[g] = rtype & fn_hot_i[R_FN_TAB[g]];
        end
        for (genvar g = 0; g < N_I; g++) begin : g_ifmt
            assign id_o[N_R + g] = op_hot_i[I_OP_TAB[g]];
        end
    endgenerate

    // Guard: no decoder line outside the instruction set may be active
    assign legal_o = ~(|(op_hot_i & ~OP_USED)) & ~(rtype & (|(fn_hot_i & ~FN_USED)));
endmodule

// File: rtl/icd_ctrl_gen.sv
module icd_ctrl_gen
    import icd_pkg::*;
(
    input  logic [N_ID-1:0] id_i,
    input  logic            legal_i,
    output ctrl_t           ctrl_o
);
    logic arith, logi, imm, r_alu;

    always_comb begin
        arith = id_i[ID_ADD] | id_i[ID_SUB] | id_i[ID_SLT] | id_i[ID_ADDI] | id_i[ID_SLTI];
        logi  = id_i[ID_AND] | id_i[ID_OR] | id_i[ID_XOR] | id_i[ID_NOR]
              | id_i[ID_ANDI] | id_i[ID_ORI] | id_i[ID_XORI];
        imm   = id_i[ID_LUI] | id_i[ID_ADDI] | id_i[ID_SLTI]
              | id_i[ID_ANDI] | id_i[ID_ORI] | id_i[ID_XORI];
        r_alu = id_i[ID_ADD] | id_i[ID_SUB] | id_i[ID_SLT] | id_i[ID_AND]
              | id_i[ID_OR] | id_i[ID_XOR] | id_i[ID_NOR];

        ctrl_o        = '0;
        ctrl_o.id     = id_i;
        ctrl_o.arith  = arith;
        ctrl_o.logi   = logi;
        ctrl_o.imm    = imm;
        ctrl_o.reg_wr = legal_i & (id_i[ID_LUI] | arith | logi | id_i[ID_LW] | id_i[ID_JAL]);

        ctrl_o.dst_sel[0] = r_alu;
        ctrl_o.dst_sel[1] = id_i[ID_JAL];

        ctrl_o.alu_src = imm | id_i[ID_LW] | id_i[ID_SW];
        ctrl_o.add_sub = id_i[ID_SUB] | id_i[ID_SLT] | id_i[ID_SLTI];

        ctrl_o.alu_cls[1] = id_i[ID_ADD] | id_i[ID_SUB] | id_i[ID_ADDI]
                          | id_i[ID_LW] | id_i[ID_SW] | logi;
        ctrl_o.alu_cls[0] = id_i[ID_SLT] | id_i[ID_SLTI] | logi;

        ctrl_o.logic_fn[0] = id_i[ID_OR] | id_i[ID_ORI] | id_i[ID_NOR];
        ctrl_o.logic_fn[1] = id_i[ID_XOR] | id_i[ID_XORI] | id_i[ID_NOR];

        ctrl_o.mem_rd = legal_i & id_i[ID_LW];
        ctrl_o.mem_wr = legal_i & id_i[ID_SW];

        ctrl_o.wb_sel[0] = id_i[ID_LW];
        ctrl_o.wb_sel[1] = id_i[ID_JAL];

        ctrl_o.br_type[0] = id_i[ID_BEQ] | id_i[ID_BLTZ];
        ctrl_o.br_type[1] = id_i[ID_BNE] | id_i[ID_BLTZ];

        ctrl_o.pc_sel[0] = id_i[ID_J] | id_i[ID_JAL] | id_i[ID_SYS];
        ctrl_o.pc_sel[1] = id_i[ID_JR] | id_i[ID_SYS];

        ctrl_o.sext = id_i[ID_ADDI] | id_i[ID_SLTI] | id_i[ID_LW] | id_i[ID_SW]
                    | id_i[ID_BLTZ] | id_i[ID_BEQ] | id_i[ID_BNE];
    end
endmodule

// File: rtl/insn_ctrl_decoder.sv
module insn_ctrl_decoder
    import icd_pkg::*;
#(
    parameter int OP_W = 6,
    parameter int FN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  op_i,
    input  logic [FN_W-1:0]  fn_i,
    output logic [21:0]      insn_id_o,
    output logic             is_arith_o,
    output logic             is_logic_o,
    output logic             is_imm_o,
    output logic             reg_wr_o,
    output logic [1:0]       dst_sel_o,
    output logic             alu_src_o,
    output logic             add_sub_o,
    output logic [1:0]       alu_cls_o,
    output logic [1:0]       logic_fn_o,
    output logic             mem_rd_o,
    output logic             mem_wr_o,
    output logic [1:0]       wb_sel_o,
    output logic [1:0]       br_type_o,
    output logic [1:0]       pc_sel_o,
    output logic             sext_o
);
    localparam int OP_N = 1 << OP_W;
    localparam int FN_N = 1 << FN_W;

    logic [OP_N-1:0] op_hot;
    logic [FN_N-1:0] fn_hot;
    logic [N_ID-1:0] id;
    logic            legal;
    ctrl_t           gen;
    ctrl_t           st_d;
    ctrl_t           st_q;

    icd_onehot_dec #(.W(OP_W)) u_op_dec (.code_i(op_i), .hot_o(op_hot));
    icd_onehot_dec #(.W(FN_W)) u_fn_dec (.code_i(fn_i), .hot_o(fn_hot));

    icd_ident #(.OP_N(OP_N), .FN_N(FN_N)) u_ident (
        .op_hot_i (op_hot),
        .fn_hot_i (fn_hot),
        .id_o     (id),
        .legal_o  (legal)
    );

    icd_ctrl_gen u_gen (
        .id_i    (id),
        .legal_i (legal),
        .ctrl_o  (gen)
    );

    always_comb begin
        st_d = gen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign insn_id_o  = st_q.id;
    assign is_arith_o = st_q.arith;
    assign is_logic_o = st_q.logi;
    assign is_imm_o   = st_q.imm;
    assign reg_wr_o   = st_q.reg_wr;
    assign dst_sel_o  = st_q.dst_sel;
    assign alu_src_o  = st_q.alu_src;
    assign add_sub_o  = st_q.add_sub;
    assign alu_cls_o  = st_q.alu_cls;
    assign logic_fn_o = st_q.logic_fn;
    assign mem_rd_o   = st_q.mem_rd;
    assign mem_wr_o   = st_q.mem_wr;
    assign wb_sel_o   = st_q.wb_sel;
    assign br_type_o  = st_q.br_type;
    assign pc_sel_o   = st_q.pc_sel;
    assign sext_o     = st_q.sext;
endmodule

// File: rtl/icd_checker.sv
module icd_checker #(
    parameter int OP_W = 6,
    parameter int FN_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic [OP_W-1:0] op_i,
    input logic [FN_W-1:0] fn_i,
    input logic [21:0]     insn_id_o,
    input logic            is_arith_o,
    input logic            is_logic_o,
    input logic            is_imm_o,
    input logic            reg_wr_o,
    input logic [1:0]      dst_sel_o,
    input logic            alu_src_o,
    input logic            mem_rd_o,
    input logic            mem_wr_o,
    input logic [1:0]      wb_sel_o,
    input logic [1:0]      pc_sel_o,
    input logic            sext_o
);
    a_r2_id_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(insn_id_o));

    a_r14_unknown_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_id_o == '0) |-> (!reg_wr_o && !mem_wr_o && !mem_rd_o));

    a_r9_mem_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    a_r9_load_from_op: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> ($past(op_i) == OP_W'(35)));

    a_r7_imm_src: assert property (@(posedge clk) disable iff (!rst_n)
        is_imm_o |-> alu_src_o);

    a_r5_class_write: assert property (@(posedge clk) disable iff (!rst_n)
        (is_arith_o || is_logic_o) |-> reg_wr_o);

    a_r12_reg_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel_o == 2'd2) |-> ($past(op_i) == '0 && $past(fn_i) == FN_W'(8)));

    a_r6_link_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_sel_o == 2'd2) |-> (wb_sel_o == 2'd2 && reg_wr_o));

    a_r13_logic_zext: assert property (@(posedge clk) disable iff (!rst_n)
        (is_logic_o && is_imm_o) |-> !sext_o);
endmodule

bind insn_ctrl_decoder icd_checker #(.OP_W(OP_W), .FN_W(FN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op_i),
    .fn_i       (fn_i),
    .insn_id_o  (insn_id_o),
    .is_arith_o (is_arith_o),
    .is_logic_o (is_logic_o),
    .is_imm_o   (is_imm_o),
    .reg_wr_o   (reg_wr_o),
    .dst_sel_o  (dst_sel_o),
    .alu_src_o  (alu_src_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .wb_sel_o   (wb_sel_o),
    .pc_sel_o   (pc_sel_o),
    .sext_o     (sext_o)
);

// File: tb/insn_ctrl_decoder_tb.sv
module insn_ctrl_decoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] op = '0;
    logic [5:0] fn = '0;

    logic [21:0] insn_id;
    logic is_arith, is_logic, is_imm, reg_wr, alu_src, add_sub, mem_rd, mem_wr, sext;
    logic [1:0] dst_sel, alu_cls, logic_fn, wb_sel, br_type, pc_sel;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    int e_id, e_arith, e_logic, e_imm, e_regwr, e_dst, e_src, e_addsub;
    int e_cls, e_lfn, e_mrd, e_mwr, e_wb, e_br, e_pc, e_sext;

    always #5 clk = ~clk;

    insn_ctrl_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .fn_i(fn),
        .insn_id_o(insn_id), .is_arith_o(is_arith), .is_logic_o(is_logic),
        .is_imm_o(is_imm), .reg_wr_o(reg_wr), .dst_sel_o(dst_sel),
        .alu_src_o(alu_src), .add_sub_o(add_sub), .alu_cls_o(alu_cls),
        .logic_fn_o(logic_fn), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
        .wb_sel_o(wb_sel), .br_type_o(br_type), .pc_sel_o(pc_sel), .sext_o(sext)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s op=%0d fn=%0d actual=%0h expected=%0h", tag, what, op, fn, act, exp);
        end
    endtask

    // R3: identity index from the encoding tables
    function automatic int id_of(logic [5:0] o, logic [5:0] f);
        if (o == 0) begin
            case (f)
                32: return 0;  34: return 1;  42: return 2;
                36: return 3;  37: return 4;  38: return 5;
                39: return 6;  8:  return 7;  12: return 8;
                default: return -1;
            endcase
        end
        case (o)
            15: return 9;   8: return 10;  10: return 11;
            12: return 12; 13: return 13;  14: return 14;
            35: return 15; 43: return 16;   2: return 17;
            3:  return 18;  1: return 19;   4: return 20;
            5:  return 21;
            default: return -1;
        endcase
    endfunction

    task automatic set_exp(logic [5:0] o, logic [5:0] f);
        int k = id_of(o, f);
        e_id     = (k < 0) ? 0 : (1 << k);
        e_arith  = int'(k inside {0, 1, 2, 10, 11});
        e_logic  = int'(k inside {3, 4, 5, 6, 12, 13, 14});
        e_imm    = int'(k inside {[9:14]});
        e_regwr  = int'(e_arith != 0 || e_logic != 0 || k inside {9, 15, 18});
        e_dst    = (k inside {[0:6]}) ? 1 : (k == 18) ? 2 : 0;
        e_src    = int'(e_imm != 0 || k inside {15, 16});
        e_addsub = int'(k inside {1, 2, 11});
        e_cls    = (k inside {2, 11}) ? 1 :
                   (k inside {0, 1, 10, 15, 16}) ? 2 :
                   (k inside {3, 4, 5, 6, 12, 13, 14}) ? 3 : 0;
        e_lfn    = (k inside {4, 13}) ? 1 : (k inside {5, 14}) ? 2 : (k == 6) ? 3 : 0;
        e_mrd    = int'(k == 15);
        e_mwr    = int'(k == 16);
        e_wb     = (k == 15) ? 1 : (k == 18) ? 2 : 0;
        e_br     = (k == 20) ? 1 : (k == 21) ? 2 : (k == 19) ? 3 : 0;
        e_pc     = (k inside {17, 18}) ? 1 : (k == 7) ? 2 : (k == 8) ? 3 : 0;
        e_sext   = int'(k inside {10, 11, 15, 16, 19, 20, 21});
    endtask

    task automatic check_all();
        chk("R2", "insn_id", int'(insn_id), e_id);
        chk("R4", "is_arith", int'(is_arith), e_arith);
        chk("R4", "is_logic", int'(is_logic), e_logic);
        chk("R4", "is_imm", int'(is_imm), e_imm);
        chk("R5", "reg_wr", int'(reg_wr), e_regwr);
        chk("R6", "dst_sel", int'(dst_sel), e_dst);
        chk("R7", "alu_src", int'(alu_src), e_src);
        chk("R8", "add_sub", int'(add_sub), e_addsub);
        chk("R8", "alu_cls", int'(alu_cls), e_cls);
        chk("R8", "logic_fn", int'(logic_fn), e_lfn);
        chk("R9", "mem_rd", int'(mem_rd), e_mrd);
        chk("R9", "mem_wr", int'(mem_wr), e_mwr);
        chk("R10", "wb_sel", int'(wb_sel), e_wb);
        chk("R11", "br_type", int'(br_type), e_br);
        chk("R12", "pc_sel", int'(pc_sel), e_pc);
        chk("R13", "sext", int'(sext), e_sext);
    endtask

    // Drive at a falling edge, sample at the next falling edge (one register)
    task automatic apply(logic [5:0] o, logic [5:0] f);
        @(negedge clk);
        op = o;
        fn = f;
        @(negedge clk);
        set_exp(o, f);
        check_all();
    endtask

    task automatic all_zero(string tag);
        chk(tag, "insn_id", int'(insn_id), 0);
        chk(tag, "flags", int'({is_arith, is_logic, is_imm, reg_wr, alu_src, add_sub,
                                mem_rd, mem_wr, sext}), 0);
        chk(tag, "fields", int'({dst_sel, alu_cls, logic_fn, wb_sel, br_type, pc_sel}), 0);
    endtask

    task automatic t_reset();
        op = 6'd3;
        fn = 6'd0;
        repeat (2) @(negedge clk);
        all_zero("R1");
        rst_n = 1'b1;
    endtask

    task automatic t_rfmt();
        int codes [9] = '{32, 34, 42, 36, 37, 38, 39, 8, 12};
        foreach (codes[i]) apply(6'd0, 6'(codes[i]));
    endtask

    task automatic t_ifmt();
        int codes [13] = '{15, 8, 10, 12, 13, 14, 35, 43, 2, 3, 1, 4, 5};
        foreach (codes[i]) apply(6'(codes[i]), 6'd17);
    endtask

    // R3: fn must not affect a non-zero opcode, even when it names an R-format op
    task automatic t_fn_ignored();
        apply(6'd35, 6'd32);
        apply(6'd8, 6'd8);
        apply(6'd43, 6'd12);
        apply(6'd3, 6'd42);
        chk("R3", "lw_with_add_fn", int'(mem_rd & ~is_arith), 0);
    endtask

    // R14: full sweeps of both code spaces
    task automatic t_sweep();
        for (int o = 0; o < 64; o++) apply(6'(o), 6'd63);
        for (int f = 0; f < 64; f++) apply(6'd0, 6'(f));
        apply(6'd63, 6'd32);
        chk("R14", "unknown_no_write", int'({reg_wr, mem_rd, mem_wr}), 0);
    endtask

    // R2: output changes only at the clock edge
    task automatic t_latency();
        apply(6'd35, 6'd0);
        @(negedge clk);
        op = 6'd43;
        #2;
        chk("R2", "before_edge_mem_rd", int'(mem_rd), 1);
        chk("R2", "before_edge_mem_wr", int'(mem_wr), 0);
        @(negedge clk);
        chk("R2", "after_edge_mem_rd", int'(mem_rd), 0);
        chk("R2", "after_edge_mem_wr", int'(mem_wr), 1);
    endtask

    // R1: asynchronous clear in the middle of a jal
    task automatic t_reset_mid();
        apply(6'd3, 6'd0);
        #1;
        rst_n = 1'b0;
        #1;
        all_zero("R1");
        @(negedge clk);
        rst_n = 1'b1;
        apply(6'd3, 6'd0);
    endtask

    initial begin
        t_reset();
        t_rfmt();
        t_ifmt();
        t_fn_ignored();
        t_sweep();
        t_latency();
        t_reset_mid();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule